// File: doc/BRIEF.md
# Serial LED Driver Chain Sequencer

This block sits on the host side of a daisy chain of identical constant-current LED drivers. Each driver has a serial shift port and a mode line. The mode line picks one of two frames. One frame carries a 7-bit brightness-correction word per channel. The other carries a single enable bit per channel. A one-cycle `start` with `cmd_dc` selects which full frame to send. The sequencer then drives the mode line, the shift clock, the serial data and the latch strobe in a safe order. While it does this it also reads back the bits the chain returns on its serial output.

Enable-bit frames are always latched inside a blanking window, so that outputs never glitch while the enable registers load. While the enables shift in, the chain returns the open-LED flags it captured at the previous latch. These flags are collected into `lod_flags`. The shift clock comes from the system clock: each SCLK phase lasts `HALF` cycles, the strobe is `XW` cycles wide and the guard intervals are `GAP` cycles long. These can be set so the drivers' minimum pulse widths and setup and hold times are met.

Top module: `led_chain_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `drv_sclk` and `drv_xlat` are low, `drv_blank` is high (outputs dark until the first enable frame) and `lod_flags` is all zero.
- R2: A correction command (`cmd_dc`=1) holds `drv_mode` high and produces exactly 112·N_DEV SCLK rising edges, followed by exactly one `drv_xlat` pulse.
- R3: An enable command (`cmd_dc`=0) holds `drv_mode` low and produces exactly 16·N_DEV SCLK rising edges, followed by one `drv_xlat` pulse.
- R4: Bit order on `drv_sin` follows the frame layout:
  - Bit L-1 of the frame vector goes out first and bit 0 goes out last, where L is the frame length.
  - Device k occupies bits [k·W +: W] of the vector, and device N_DEV-1 is the one farthest from the host.
  - Within a device word, channel c sits at bits [c·7 +: 7] for correction data and at bit c for enable data.
  - `drv_sin` changes only on a falling SCLK edge.
- R5: Cycle timing:
  - Each SCLK low and high phase lasts `HALF` clock cycles.
  - `drv_xlat` stays high for `XW` cycles.
  - Exactly `GAP` cycles separate the last SCLK fall from the XLAT rise.
  - Exactly `GAP` cycles separate the XLAT fall from the end of `busy`.
- R6: For an enable command, `drv_blank` goes high in the cycle after the last SCLK fall. It stays high through the latch and the following guard interval, and drops in the cycle where `busy` falls. A correction command leaves `drv_blank` unchanged.
- R7: Readback:
  - During an enable command, `drv_sout` is sampled at each SCLK rise.
  - The first sample lands in `lod_flags[16·N_DEV-1]` and the last in `lod_flags[0]`.
  - `lod_flags` is updated when the command completes.
  - A correction command leaves `lod_flags` unchanged.
- R8: `drv_mode` changes only when a command is accepted. It is stable for the whole time `busy` is high.
- R9: Handshake:
  - `start` is accepted only while `busy` is low, and a `start` raised while busy is ignored.
  - `busy` rises on the cycle after acceptance.
  - `done` is a one-cycle pulse in the first cycle where `busy` is low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command request, sampled while idle |
| cmd_dc | input | 1 | 1 = correction frame, 0 = enable frame |
| dc_data | input | 112·N_DEV | Correction frame (layout per R4) |
| onoff_data | input | 16·N_DEV | Enable frame (layout per R4) |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| lod_flags | output | 16·N_DEV | Open-LED flags read back during the last enable frame |
| drv_mode | output | 1 | Chain frame-select line |
| drv_sclk | output | 1 | Chain shift clock |
| drv_sin | output | 1 | Chain serial data |
| drv_xlat | output | 1 | Chain latch strobe |
| drv_blank | output | 1 | Chain output blanking |
| drv_sout | input | 1 | Serial data returned by the chain |

## Verification
The two actions that meet in a single clock edge are the return-bit capture and the outgoing clock edge. The sample of `drv_sout` is taken on the same system edge that raises `drv_sclk`. The bench's chain model shifts on that rising SCLK edge, so a capture one edge late would record the next device bit. Preloading the chain with distinct patterns and comparing `lod_flags` against the preload exposes any such skew. A second collision is a `start` arriving while a frame is in flight. The bench injects it in mid-shift, and every cycle is checked to confirm the frame, the mode and the cycle count are undisturbed.

// File: rtl/led_chain_ctrl.sv
module led_chain_ctrl #(
  parameter int N_DEV = 2,
  parameter int CH    = 16,
  parameter int DC_W  = 7,
  parameter int HALF  = 2,
  parameter int GAP   = 2,
  parameter int XW    = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       cmd_dc,
  input  logic [CH*DC_W*N_DEV-1:0]   dc_data,
  input  logic [CH*N_DEV-1:0]        onoff_data,
  output logic                       busy,
  output logic                       done,
  output logic [CH*N_DEV-1:0]        lod_flags,
  output logic                       drv_mode,
  output logic                       drv_sclk,
  output logic                       drv_sin,
  output logic                       drv_xlat,
  output logic                       drv_blank,
  input  logic                       drv_sout
);

  localparam int OOL  = CH * N_DEV;
  localparam int DCL  = CH * DC_W * N_DEV;
  localparam int BW   = $clog2(DCL);
  localparam int T1   = (HALF > GAP) ? HALF : GAP;
  localparam int TMAX = (T1 > XW) ? T1 : XW;
  localparam int CW   = $clog2(TMAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_LO, S_HI, S_GAP, S_XLAT, S_TAIL} st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic [BW-1:0]  left;
  logic [DCL-1:0] tx;
  logic [OOL-1:0] rx;

  wire end_half = cnt == CW'(HALF - 1);
  wire end_gap  = cnt == CW'(GAP - 1);
  wire end_x    = cnt == CW'(XW - 1);

  assign busy    = st != S_IDLE;
  assign drv_sin = tx[DCL-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      left      <= '0;
      tx        <= '0;
      rx        <= '0;
      lod_flags <= '0;
      drv_mode  <= 1'b0;
      drv_sclk  <= 1'b0;
      drv_xlat  <= 1'b0;
      drv_blank <= 1'b1;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          drv_mode <= cmd_dc;
          tx       <= cmd_dc ? dc_data : (DCL'(onoff_data) << (DCL - OOL));
          left     <= cmd_dc ? BW'(DCL - 1) : BW'(OOL - 1);
          cnt      <= '0;
          st       <= S_LO;
        end
        S_LO: if (end_half) begin
          cnt      <= '0;
          drv_sclk <= 1'b1;
          rx       <= {rx[OOL-2:0], drv_sout};
          st       <= S_HI;
        end else cnt <= cnt + 1'b1;
        S_HI: if (end_half) begin
          cnt      <= '0;
          drv_sclk <= 1'b0;
          if (left == '0) begin
            st <= S_GAP;
            if (!drv_mode) drv_blank <= 1'b1;
          end else begin
            left <= left - 1'b1;
            tx   <= tx << 1;
            st   <= S_LO;
          end
        end else cnt <= cnt + 1'b1;
        S_GAP: if (end_gap) begin
          cnt      <= '0;
          drv_xlat <= 1'b1;
          st       <= S_XLAT;
        end else cnt <= cnt + 1'b1;
        S_XLAT: if (end_x) begin
          cnt      <= '0;
          drv_xlat <= 1'b0;
          st       <= S_TAIL;
        end else cnt <= cnt + 1'b1;
        S_TAIL: if (end_gap) begin
          cnt  <= '0;
          st   <= S_IDLE;
          done <= 1'b1;
          if (!drv_mode) begin
            drv_blank <= 1'b0;
            lod_flags <= rx;
          end
        end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/led_chain_ctrl_chk.sv
module led_chain_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic sclk,
  input logic sin,
  input logic xlat,
  input logic blank,
  input logic mode
);

  // R9
  strobe_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xlat |-> busy);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(mode));

  // R6
  blank_at_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xlat && !mode |-> blank);

  // R5
  no_clk_in_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sclk && xlat));

  // R4
  sin_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk && $past(sclk) |-> $stable(sin));

  // R4
  sin_steady_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(sin));

endmodule

bind led_chain_ctrl led_chain_ctrl_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .busy  (busy),
  .done  (done),
  .sclk  (drv_sclk),
  .sin   (drv_sin),
  .xlat  (drv_xlat),
  .blank (drv_blank),
  .mode  (drv_mode)
);

// File: tb/tb_led_chain_ctrl.sv
module tb_led_chain_ctrl;
  localparam int PER   = 10;
  localparam int N_DEV = 2;
  localparam int HALF  = 2;
  localparam int GAP   = 2;
  localparam int XW    = 2;
  localparam int OOL   = 16 * N_DEV;
  localparam int DCL   = 112 * N_DEV;

  logic clk = 0, rst_n = 0, start = 0, cmd_dc = 0;
  logic [DCL-1:0] dc_data = '0;
  logic [OOL-1:0] onoff_data = '0;
  logic busy, done, drv_mode, drv_sclk, drv_sin, drv_xlat, drv_blank, drv_sout;
  logic [OOL-1:0] lod_flags;

  logic [DCL-1:0] chain, pl;
  logic load_pl = 0;
  always @(posedge drv_sclk or posedge load_pl)
    if (load_pl) chain <= pl;
    else chain <= {chain[DCL-2:0], drv_sin};
  assign drv_sout = drv_mode ? chain[DCL-1] : chain[OOL-1];

  led_chain_ctrl #(.N_DEV(N_DEV), .HALF(HALF), .GAP(GAP), .XW(XW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_dc(cmd_dc),
    .dc_data(dc_data), .onoff_data(onoff_data), .busy(busy), .done(done),
    .lod_flags(lod_flags), .drv_mode(drv_mode), .drv_sclk(drv_sclk),
    .drv_sin(drv_sin), .drv_xlat(drv_xlat), .drv_blank(drv_blank),
    .drv_sout(drv_sout));

  always #(PER/2) clk = ~clk;

  int vectors = 0, miscompares = 0;
  logic exp_blank = 1'b1;
  logic [OOL-1:0] exp_lod = '0;

  task automatic chk(string req, string nm, logic [DCL-1:0] act, logic [DCL-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h @%0t", req, nm, act, exp, $time);
    end
  endtask

  task automatic preload(logic [DCL-1:0] v);
    pl = v;
    load_pl = 1;
    #1 load_pl = 0;
  endtask

  task automatic run(logic dc, logic [DCL-1:0] dcv, logic [OOL-1:0] oov,
                     logic [DCL-1:0] pre, bit poke);
    int L = dc ? DCL : OOL;
    int T = 2*HALF*L + 2*GAP + XW;
    logic [DCL-1:0] data = dc ? dcv : DCL'(oov);
    preload(pre);
    @(negedge clk);
    cmd_dc = dc; dc_data = dcv; onoff_data = oov; start = 1;
    @(negedge clk);
    start = 0;
    for (int t = 0; t <= T + 1; t++) begin
      logic e_sclk, e_xlat, e_blank, e_busy, e_done;
      e_busy  = t < T;
      e_done  = t == T;
      e_sclk  = t < 2*HALF*L && (t % (2*HALF)) >= HALF;
      e_xlat  = t >= 2*HALF*L + GAP && t < 2*HALF*L + GAP + XW;
      if (dc) e_blank = exp_blank;
      else    e_blank = (t < 2*HALF*L) ? exp_blank : (t < T);
      chk("R9", "busy", DCL'(busy), DCL'(e_busy));
      chk("R9", "done", DCL'(done), DCL'(e_done));
      chk(dc ? "R2" : "R3", "sclk", DCL'(drv_sclk), DCL'(e_sclk));
      chk("R5", "xlat", DCL'(drv_xlat), DCL'(e_xlat));
      chk("R6", "blank", DCL'(drv_blank), DCL'(e_blank));
      chk("R8", "mode", DCL'(drv_mode), DCL'(dc));
      if (t < 2*HALF*L)
        chk("R4", "sin", DCL'(drv_sin), DCL'(data[L-1-t/(2*HALF)]));
      if (t == T) begin
        if (!dc) exp_lod = pre[OOL-1:0];
        chk("R7", "lod_flags", DCL'(lod_flags), DCL'(exp_lod));
        if (dc) chk("R2", "chain_dc", chain, dcv);
        else    chk("R3", "chain_oo", DCL'(chain[OOL-1:0]), DCL'(oov));
      end
      if (poke && t == 5) begin start = 1; cmd_dc = ~dc; end
      @(negedge clk);
      if (poke && t == 5) start = 0;
    end
    if (!dc) exp_blank = 1'b0;
  endtask

  function automatic logic [DCL-1:0] rnd();
    logic [DCL-1:0] v;
    for (int i = 0; i < DCL; i += 32) v = {v[DCL-33:0], $urandom()};
    return v;
  endfunction

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(PER*150000);
    miscompares++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    preload('0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "busy", DCL'(busy), '0);
    chk("R1", "done", DCL'(done), '0);
    chk("R1", "sclk", DCL'(drv_sclk), '0);
    chk("R1", "xlat", DCL'(drv_xlat), '0);
    chk("R1", "blank", DCL'(drv_blank), DCL'(1));
    chk("R1", "lod", DCL'(lod_flags), '0);
    run(1'b1, rnd(), '0, '0, 1'b0);
    run(1'b0, '0, 32'hA5C3_0F81, DCL'(32'h8001_7E3C), 1'b0);
    run(1'b0, '0, 32'h1234_FEDC, DCL'(32'hC0DE_5A5A), 1'b1);
    run(1'b1, rnd(), '0, rnd(), 1'b1);
    run(1'b0, '0, '1, '0, 1'b0);
    run(1'b0, '0, '0, DCL'({OOL{1'b1}}), 1'b0);
    run(1'b1, {DCL{1'b1}}, '0, '0, 1'b0);
    summary();
  end
endmodule